// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block holds the eight-bit status byte of a serial EEPROM and decides, cycle by cycle, whether a write to the memory array or to the status byte may go ahead. Other blocks handle opcode parsing, storage and the counter comparison. They hand this unit one-cycle strobes for write-enable set, write-enable clear, status write (with its data byte) and write completion. They also supply the address being written, the busy flag of the self-timed write engine and the comparator result. In return the unit drives the byte for a status read and two permit levels, one for the array and one for the status byte.

There are two protection levels. Block-protect bits fence off the top of the array. When the sticky lock bit is set and the protect pin is low, the status byte itself is frozen too. The first 32-byte page holds the monotonic counters and is never covered by block protection. A status write is first captured as pending. The non-volatile bits keep their old value on reads until the write engine reports completion. The enable and busy bits always follow the live state.

Top module: `sr_guard`

## Requirements
- R1: The status byte is {lock, erased, 0, cmp, bp[1], bp[0], wel, wip} from bit 7 down to bit 0. After the initial-state reset it reads 0x10 while `uv_i` and `busy_i` are low. Bit 6 follows `uv_i`.
- R2: A `wren_i` strobe sets wel (bit 1) and a `wrdi_i` strobe clears it. When both arrive in the same cycle, wel ends cleared.
- R3: A `wr_done_i` strobe clears wel. Bits 1 and 0 of the status-write data never reach wel or wip.
- R4: Bit 0 (wip) equals `busy_i` in the same cycle.
- R5: A status write is taken only while `sr_wr_ok_o` is high. It stores bits 7, 3 and 2 of the data as pending. Those values appear as lock, bp[1] and bp[0] only after the next `wr_done_i`, and until then reads return the old values.
- R6: `sr_wr_ok_o` is high exactly when wel is 1, `busy_i` is 0, and not (lock is 1 and `wp_n` is 0).
- R7: `arr_wr_ok_o` needs wel = 1, `busy_i` = 0 and an address outside the protected range. The range is selected by bp: 00 none, 01 0x300–0x3FF, 10 0x200–0x3FF, 11 0x020–0x3FF.
- R8: Addresses 0x000–0x01F are never protected by bp.
- R9: A soft reset (`rst_n` low) clears wel and any pending status write and keeps lock, bp and cmp. The initial-state reset (`init_n` low) also returns lock and bp to 0 and cmp to 1.
- R10: A `cmp_vld_i` strobe loads cmp (bit 4) from `cmp_lower_i`.
- R11: Hardware lock takes effect whether lock is set before or after the pin goes low. Raising the pin lifts it and leaves bp unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, asynchronous |
| init_n | input | 1 | Initial-state reset for the non-volatile bits, active low, asynchronous |
| wp_n | input | 1 | Write-protect pin, low engages hardware lock when lock bit set |
| wren_i | input | 1 | Write-enable set strobe |
| wrdi_i | input | 1 | Write-enable clear strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| wr_done_i | input | 1 | Write cycle completion strobe |
| busy_i | input | 1 | Self-timed write in progress |
| uv_i | input | 1 | Erased indication from the array |
| cmp_vld_i | input | 1 | Comparator result strobe |
| cmp_lower_i | input | 1 | Comparator result: new value was lower |
| addr_i | input | ADDR_W | Target byte address |
| status_o | output | 8 | Status byte for reads |
| arr_wr_ok_o | output | 1 | Array write permitted at addr_i |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
On every cycle the assertions check that a hardware lock always denies status writes, that an array permit never appears without wel and an idle engine, that the counter page never decodes as protected, that a clear strobe leaves wel low, and that the non-volatile bits move only on a completion or comparator strobe. Some behaviour is visible only in the bench's sequences. These include the frozen read-back of a pending status write, each bp range with its edge addresses, and both orders of entering the hardware lock. They also include the different reach of the two resets and a status write refused while busy.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
        logic       cmp;
    } nv_t;

    typedef struct packed {
        logic       wel;
        logic       pend_vld;
        logic       pend_lock;
        logic [1:0] pend_bp;
    } vol_t;

    localparam nv_t  NV_INIT  = '{lock: 1'b0, bp: 2'b00, cmp: 1'b1};
    localparam vol_t VOL_INIT = '{wel: 1'b0, pend_vld: 1'b0, pend_lock: 1'b0, pend_bp: 2'b00};

    // status byte positions
    localparam int B_LOCK = 7;
    localparam int B_UV   = 6;
    localparam int B_CMP  = 4;
    localparam int B_BP1  = 3;
    localparam int B_BP0  = 2;
    localparam int B_WEL  = 1;
    localparam int B_WIP  = 0;

endpackage

// File: rtl/sr_range_dec.sv
module sr_range_dec #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    output logic              hit
);
    localparam int MEM_BYTES = 2 ** ADDR_W;
    localparam logic [ADDR_W-1:0] LIM_QTR  = ADDR_W'(MEM_BYTES - MEM_BYTES / 4);
    localparam logic [ADDR_W-1:0] LIM_HALF = ADDR_W'(MEM_BYTES / 2);
    localparam logic [ADDR_W-1:0] LIM_PAGE = ADDR_W'(PAGE_BYTES);

    logic above_page;
    logic raw_hit;

    always_comb begin
        above_page = (addr >= LIM_PAGE);
        unique case (bp)
            2'b00:   raw_hit = 1'b0;
            2'b01:   raw_hit = (addr >= LIM_QTR);
            2'b10:   raw_hit = (addr >= LIM_HALF);
            default: raw_hit = 1'b1;
        endcase
        hit = raw_hit && above_page;
    end

    // R8
    page_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < LIM_PAGE) |-> !hit);

endmodule

// File: rtl/sr_state_regs.sv
module sr_state_regs
    import sr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_n,
    input  logic       wren,
    input  logic       wrdi,
    input  logic       wrsr_take,
    input  logic [7:0] wrsr_data,
    input  logic       wr_done,
    input  logic       cmp_vld,
    input  logic       cmp_lower,
    output nv_t        nv,
    output logic       wel
);
    nv_t  nv_d,  nv_q;
    vol_t vol_d, vol_q;

    logic unused_data_bits;
    assign unused_data_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

    always_comb begin
        nv_d  = nv_q;
        vol_d = vol_q;
        if (wren) vol_d.wel = 1'b1;
        if (wrdi) vol_d.wel = 1'b0;
        if (wr_done) begin
            vol_d.wel = 1'b0;
            if (vol_q.pend_vld) begin
                nv_d.lock = vol_q.pend_lock;
                nv_d.bp   = vol_q.pend_bp;
            end
            vol_d.pend_vld = 1'b0;
        end
        if (wrsr_take) begin
            vol_d.pend_vld  = 1'b1;
            vol_d.pend_lock = wrsr_data[B_LOCK];
            vol_d.pend_bp   = wrsr_data[B_BP1:B_BP0];
        end
        if (cmp_vld) nv_d.cmp = cmp_lower;
    end

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) nv_q <= NV_INIT;
        else         nv_q <= nv_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q <= VOL_INIT;
        else        vol_q <= vol_d;
    end

    assign nv  = nv_q;
    assign wel = vol_q.wel;

    // R2
    wrdi_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        wrdi |=> !wel);

    // R5
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (!wr_done && !cmp_vld) |=> $stable(nv));

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              wp_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              wr_done_i,
    input  logic              busy_i,
    input  logic              uv_i,
    input  logic              cmp_vld_i,
    input  logic              cmp_lower_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    nv_t  nv;
    logic wel;
    logic prot_hit;
    logic hw_lock;
    logic sr_ok;
    logic arr_ok;

    sr_range_dec #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) range_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_i),
        .bp    (nv.bp),
        .hit   (prot_hit)
    );

    sr_state_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_n    (init_n),
        .wren      (wren_i),
        .wrdi      (wrdi_i),
        .wrsr_take (wrsr_i && sr_ok),
        .wrsr_data (wrsr_data_i),
        .wr_done   (wr_done_i),
        .cmp_vld   (cmp_vld_i),
        .cmp_lower (cmp_lower_i),
        .nv        (nv),
        .wel       (wel)
    );

    always_comb begin
        hw_lock = nv.lock && !wp_n;
        sr_ok   = wel && !busy_i && !hw_lock;
        arr_ok  = wel && !busy_i && !prot_hit;
        status_o          = 8'h00;
        status_o[B_LOCK]  = nv.lock;
        status_o[B_UV]    = uv_i;
        status_o[B_CMP]   = nv.cmp;
        status_o[B_BP1]   = nv.bp[1];
        status_o[B_BP0]   = nv.bp[0];
        status_o[B_WEL]   = wel;
        status_o[B_WIP]   = busy_i;
    end

    assign arr_wr_ok_o = arr_ok;
    assign sr_wr_ok_o  = sr_ok;

    // R6 R11
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (status_o[B_LOCK] && !wp_n) |-> !sr_wr_ok_o);

    // R7
    arr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        arr_wr_ok_o |-> (status_o[B_WEL] && !busy_i));

endmodule

// File: tb/sr_guard_tb_top.sv
module sr_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, done = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       busy = 1'b0, uv = 1'b0, cvld = 1'b0, clow = 1'b0;
    logic [9:0] addr = 10'h100;
    logic [7:0] status;
    logic       arr_ok, sr_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sr_guard dut_i (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .wp_n(wp_n),
        .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .wrsr_data_i(wdata),
        .wr_done_i(done), .busy_i(busy), .uv_i(uv), .cmp_vld_i(cvld),
        .cmp_lower_i(clow), .addr_i(addr), .status_o(status),
        .arr_wr_ok_o(arr_ok), .sr_wr_ok_o(sr_ok)
    );

    // {op[2:0], data[7:0], addr[9:0], wp_n, busy, status[7:0], arr_ok, sr_ok}
    // op: 0 idle, 1 set-enable, 2 clear-enable, 3 status write, 4 completion
    localparam int NV = 18;
    localparam logic [32:0] VEC [NV] = '{
        {3'd0, 8'h00, 10'h100, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0}, // R1 init
        {3'd1, 8'h00, 10'h100, 1'b1, 1'b0, 8'h12, 1'b1, 1'b1}, // R2 set
        {3'd2, 8'h00, 10'h100, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0}, // R2 clear
        {3'd1, 8'h00, 10'h100, 1'b1, 1'b0, 8'h12, 1'b1, 1'b1}, // R2
        {3'd3, 8'hFF, 10'h100, 1'b1, 1'b0, 8'h12, 1'b1, 1'b1}, // R5 pending, frozen
        {3'd0, 8'h00, 10'h100, 1'b1, 1'b1, 8'h13, 1'b0, 1'b0}, // R4 busy live
        {3'd4, 8'h00, 10'h100, 1'b1, 1'b0, 8'h9C, 1'b0, 1'b0}, // R3 R5 commit
        {3'd1, 8'h00, 10'h100, 1'b1, 1'b0, 8'h9E, 1'b0, 1'b1}, // R7 bp11
        {3'd0, 8'h00, 10'h010, 1'b1, 1'b0, 8'h9E, 1'b1, 1'b1}, // R8 page
        {3'd0, 8'h00, 10'h010, 1'b0, 1'b0, 8'h9E, 1'b1, 1'b0}, // R6 lock
        {3'd3, 8'h00, 10'h010, 1'b0, 1'b0, 8'h9E, 1'b1, 1'b0}, // R6 ignored
        {3'd4, 8'h00, 10'h010, 1'b0, 1'b0, 8'h9C, 1'b0, 1'b0}, // R3 R6
        {3'd1, 8'h00, 10'h010, 1'b1, 1'b0, 8'h9E, 1'b1, 1'b1}, // R11 pin high
        {3'd3, 8'h04, 10'h010, 1'b1, 1'b0, 8'h9E, 1'b1, 1'b1}, // R5
        {3'd4, 8'h00, 10'h010, 1'b1, 1'b0, 8'h14, 1'b0, 1'b0}, // R5 commit
        {3'd1, 8'h00, 10'h2FF, 1'b1, 1'b0, 8'h16, 1'b1, 1'b1}, // R7 bp01 edge
        {3'd0, 8'h00, 10'h300, 1'b1, 1'b0, 8'h16, 1'b0, 1'b1}, // R7
        {3'd0, 8'h00, 10'h3FF, 1'b0, 1'b0, 8'h16, 1'b0, 1'b1}  // R6 R7
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [7:0] es, input logic ea, input logic ew);
        chk(tag, status, es);
        chk(tag, {7'd0, arr_ok}, {7'd0, ea});
        chk(tag, {7'd0, sr_ok}, {7'd0, ew});
    endtask

    task automatic pulse(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        wdata = d;
        wren = (op == 3'd1);
        wrdi = (op == 3'd2);
        wrsr = (op == 3'd3);
        done = (op == 3'd4);
        @(negedge clk);
        {wren, wrdi, wrsr, done} = 4'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; init_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr = VEC[i][21:12];
            wp_n = VEC[i][11];
            busy = VEC[i][10];
            pulse(VEC[i][32:30], VEC[i][29:22]);
            chk($sformatf("vec%0d", i), status, VEC[i][9:2]);
            chk($sformatf("vec%0d arr", i), {7'd0, arr_ok}, {7'd0, VEC[i][1]});
            chk($sformatf("vec%0d sr", i), {7'd0, sr_ok}, {7'd0, VEC[i][0]});
        end
        // R9 soft reset keeps bp
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk_all("R9 soft", 8'h14, 1'b0, 1'b0);
        // R2 simultaneous set and clear
        @(negedge clk); wren = 1'b1; wrdi = 1'b1; @(negedge clk); wren = 1'b0; wrdi = 1'b0;
        chk_all("R2 both", 8'h14, 1'b0, 1'b0);
        // R11 pin low first, then lock set
        wp_n = 1'b0; addr = 10'h1FF;
        pulse(3'd1, 8'h00);
        chk_all("R11 pre", 8'h16, 1'b1, 1'b1);
        pulse(3'd3, 8'h8B);
        pulse(3'd4, 8'h00);
        chk_all("R11 commit R3", 8'h98, 1'b0, 1'b0);
        pulse(3'd1, 8'h00);
        chk_all("R11 locked R7", 8'h9A, 1'b1, 1'b0);
        @(negedge clk); wp_n = 1'b1; addr = 10'h200; #1;
        chk_all("R11 release R7", 8'h9A, 1'b0, 1'b1);
        // R5 status write refused while busy
        @(negedge clk); busy = 1'b1;
        pulse(3'd3, 8'h00);
        chk_all("R5 busy R4", 8'h9B, 1'b0, 1'b0);
        @(negedge clk); busy = 1'b0;
        pulse(3'd4, 8'h00);
        chk_all("R5 no pend", 8'h98, 1'b0, 1'b0);
        // R10 comparator latch
        @(negedge clk); cvld = 1'b1; clow = 1'b0; @(negedge clk); cvld = 1'b0;
        chk("R10 low", status, 8'h88);
        @(negedge clk); cvld = 1'b1; clow = 1'b1; @(negedge clk); cvld = 1'b0;
        chk("R10 high", status, 8'h98);
        // R1 erased bit
        uv = 1'b1; #1; chk("R1 uv", status, 8'hD8); uv = 1'b0;
        // R9 initial-state reset
        @(negedge clk); init_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); init_n = 1'b1; rst_n = 1'b1;
        chk_all("R9 init", 8'h10, 1'b0, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule